// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block sits between an interrupt trigger stage and a bank of up to eight per-CPU local interrupt controllers. The trigger stage presents one delivery request at a time. A request carries a destination ID, a physical/logical flag, a three-bit delivery mode, a vector, a trigger mode and the index of the source pin. The block works out which CPUs the request addresses. It compares the destination against the physical ID of each CPU, or it uses a per-CPU logical-match input that the local controllers compute. It then issues the resulting injections one per cycle. Each injection carries a valid strobe, the vector, the trigger mode and a one-hot CPU select.

Fixed and external-interrupt requests are copied to every addressed CPU in ascending order. Lowest-priority requests go to a single CPU, which a round-robin pointer chooses. A request from the pin wired to the legacy timer IRQ 0 is pinned to CPU 0 while the timer-enable input is high. Requests with no target, and requests in unsupported modes, are dropped silently. The trigger stage sees `req_ready` high only when no injection is outstanding.

Top module: `irq_dispatch`

## Requirements
- R1: In physical mode (`req_logical`=0), a destination of all ones (0xFF) addresses every CPU.
- R2: In physical mode, any other destination addresses only the lowest-numbered CPU whose `cpu_phys_id` equals it, even if several CPUs share that ID.
- R3: In logical mode, a destination of zero addresses no CPU. A nonzero destination addresses exactly the CPUs whose `cpu_logic_hit` bit is set.
- R4: A request whose addressed set is empty produces no injection, and `req_ready` is high again in the cycle after acceptance.
- R5: In delivery modes 0 (fixed) and 7 (external), one injection per addressed CPU is issued on consecutive cycles in ascending CPU order. Each injection has exactly one `inj_cpu` bit set and carries the request's vector and trigger mode unchanged.
- R6: In delivery mode 1 (lowest priority), exactly one injection is issued. It goes to the first addressed CPU found by searching upward from the CPU after the last one chosen, wrapping from 7 to 0. After reset the search starts at CPU 0, and the pointer moves only when such an injection is made.
- R7: When `req_pin` equals 2 (the pin of legacy IRQ 0) and `timer_en` is high, every injection of the request selects CPU 0. The number of injections is unchanged. A lowest-priority request under this override sets the round-robin pointer to CPU 0.
- R8: Delivery modes 2, 3, 4, 5 and 6 are unsupported. Such requests are dropped with no injection and do not move the round-robin pointer.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. Its first injection appears in the next cycle, and `req_ready` stays low while any injection of it remains.
- R10: After reset, `inj_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request present |
| req_ready | output | 1 | No injection outstanding; request may be taken |
| req_dest | input | ID_W (8) | Destination ID |
| req_logical | input | 1 | 0 physical, 1 logical destination |
| req_dmode | input | 3 | Delivery mode code |
| req_vector | input | VEC_W (8) | Interrupt vector |
| req_level | input | 1 | Trigger mode, 1 for level |
| req_pin | input | PIN_W (5) | Source pin index |
| timer_en | input | 1 | Legacy timer channel enabled |
| cpu_phys_id | input | NCPU*ID_W (64) | Physical ID of each CPU, CPU i in bits [i*8 +: 8] |
| cpu_logic_hit | input | NCPU (8) | Per-CPU logical-destination match |
| inj_valid | output | 1 | Injection issued this cycle |
| inj_cpu | output | NCPU (8) | One-hot target CPU |
| inj_vector | output | VEC_W (8) | Vector of the injection |
| inj_level | output | 1 | Trigger mode of the injection |

## Verification
The timer override and round-robin selection can act in the same cycle. This happens when a lowest-priority request arrives from pin 2 with `timer_en` high: the injection is redirected to CPU 0 while the pointer is also updated. The bench provokes this with an addressed set that excludes CPU 0. It then judges the outcome twice: once from the injection itself, and once from the CPU that the next, non-overridden lowest-priority request picks, which must be the first addressed CPU above 0. Fan-out and override also overlap in a fixed-mode broadcast from pin 2, which must yield eight consecutive injections, all to CPU 0.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXTINT = 3'd7
  } dmode_e;

  function automatic logic mode_fans_out(input dmode_e m);
    return (m == DM_FIXED) || (m == DM_EXTINT);
  endfunction

  function automatic logic mode_single(input dmode_e m);
    return m == DM_LOWEST;
  endfunction

endpackage

// File: rtl/irq_target_resolve.sv
module irq_target_resolve #(
  parameter int NCPU = 8,
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0]      dest,
  input  logic                 logical,
  input  logic [NCPU*ID_W-1:0] phys_ids,
  input  logic [NCPU-1:0]      logic_hit,
  output logic [NCPU-1:0]      target_mask
);

  localparam logic [ID_W-1:0] BCAST_ID = '1;

  // Lowest-index CPU whose physical ID equals the destination, one-hot.
  function automatic logic [NCPU-1:0] first_id_match(
    input logic [ID_W-1:0] d, input logic [NCPU*ID_W-1:0] ids);
    logic [NCPU-1:0] r;
    r = '0;
    for (int i = NCPU - 1; i >= 0; i--) begin
      if (ids[i*ID_W +: ID_W] == d) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    target_mask = '0;
    if (!logical) begin
      if (dest == BCAST_ID) target_mask = '1;
      else                  target_mask = first_id_match(dest, phys_ids);
    end else if (dest != '0) begin
      target_mask = logic_hit;
    end
  end

endmodule

// File: rtl/irq_rr_select.sv
module irq_rr_select #(
  parameter int NCPU = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] cand,
  input  logic            advance,
  input  logic            force_zero,
  output logic [NCPU-1:0] pick
);

  localparam int IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam logic [IDX_W-1:0] LAST_CPU = IDX_W'(NCPU - 1);

  logic [IDX_W-1:0] last_q;

  // First candidate strictly after 'last', wrapping around.
  function automatic logic [NCPU-1:0] rr_first(
    input logic [NCPU-1:0] m, input logic [IDX_W-1:0] last);
    logic [NCPU-1:0] r;
    logic            hit;
    int              idx;
    r   = '0;
    hit = 1'b0;
    for (int k = 1; k <= NCPU; k++) begin
      idx = int'(last) + k;
      if (idx >= NCPU) idx = idx - NCPU;
      if (!hit && m[idx]) begin
        r[idx] = 1'b1;
        hit    = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] onehot_index(input logic [NCPU-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (oh[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign pick = rr_first(cand, last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= LAST_CPU;
    end else if (advance) begin
      last_q <= force_zero ? '0 : onehot_index(pick);
    end
  end

endmodule

// File: rtl/irq_inj_seq.sv
module irq_inj_seq #(
  parameter int NCPU  = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCPU-1:0]  load_mask,
  input  logic [VEC_W-1:0] load_vec,
  input  logic             load_lvl,
  input  logic             load_ovr,
  output logic             inj_valid,
  output logic [NCPU-1:0]  inj_cpu,
  output logic [VEC_W-1:0] inj_vector,
  output logic             inj_level,
  output logic             idle,
  output logic             ovr_active
);

  localparam logic [NCPU-1:0] CPU0_SEL = NCPU'(1);

  logic [NCPU-1:0]  pend_q;
  logic [VEC_W-1:0] vec_q;
  logic             lvl_q;
  logic             ovr_q;
  logic [NCPU-1:0]  cur_bit;

  function automatic logic [NCPU-1:0] lowest_set(input logic [NCPU-1:0] x);
    return x & (~x + NCPU'(1));
  endfunction

  assign cur_bit    = lowest_set(pend_q);
  assign inj_valid  = |pend_q;
  assign idle       = ~inj_valid;
  assign inj_cpu    = !inj_valid ? '0 : (ovr_q ? CPU0_SEL : cur_bit);
  assign inj_vector = vec_q;
  assign inj_level  = lvl_q;
  assign ovr_active = ovr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      vec_q  <= '0;
      lvl_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (load) begin
      pend_q <= load_mask;
      vec_q  <= load_vec;
      lvl_q  <= load_lvl;
      ovr_q  <= load_ovr;
    end else if (inj_valid) begin
      pend_q <= pend_q & ~cur_bit;
    end
  end

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NCPU      = 8,
  parameter int ID_W      = 8,
  parameter int VEC_W     = 8,
  parameter int PIN_W     = 5,
  parameter int TIMER_PIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_dest,
  input  logic                 req_logical,
  input  logic [2:0]           req_dmode,
  input  logic [VEC_W-1:0]     req_vector,
  input  logic                 req_level,
  input  logic [PIN_W-1:0]     req_pin,
  input  logic                 timer_en,
  input  logic [NCPU*ID_W-1:0] cpu_phys_id,
  input  logic [NCPU-1:0]      cpu_logic_hit,
  output logic                 inj_valid,
  output logic [NCPU-1:0]      inj_cpu,
  output logic [VEC_W-1:0]     inj_vector,
  output logic                 inj_level
);

  localparam logic [PIN_W-1:0] TIMER_PIN_V = PIN_W'(TIMER_PIN);
  localparam logic [NCPU-1:0]  CPU0_SEL    = NCPU'(1);

  dmode_e          mode_w;
  logic            accept_w;
  logic            any_target_w;
  logic            timer_hit_w;
  logic            fanout_w;
  logic            single_w;
  logic            load_w;
  logic            rr_advance_w;
  logic            ovr_active_w;
  logic            seq_idle_w;
  logic [NCPU-1:0] target_w;
  logic [NCPU-1:0] rr_pick_w;
  logic [NCPU-1:0] load_mask_w;

  assign mode_w       = dmode_e'(req_dmode);
  assign accept_w     = req_valid && req_ready;
  assign any_target_w = |target_w;
  assign timer_hit_w  = timer_en && (req_pin == TIMER_PIN_V);
  assign fanout_w     = mode_fans_out(mode_w);
  assign single_w     = mode_single(mode_w);
  assign load_w       = accept_w && any_target_w && (fanout_w || single_w);
  assign rr_advance_w = accept_w && any_target_w && single_w;
  assign load_mask_w  = single_w ? (timer_hit_w ? CPU0_SEL : rr_pick_w) : target_w;
  assign req_ready    = seq_idle_w;

  irq_target_resolve #(.NCPU(NCPU), .ID_W(ID_W)) resolve_i (
    .dest        (req_dest),
    .logical     (req_logical),
    .phys_ids    (cpu_phys_id),
    .logic_hit   (cpu_logic_hit),
    .target_mask (target_w)
  );

  irq_rr_select #(.NCPU(NCPU)) rr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cand       (target_w),
    .advance    (rr_advance_w),
    .force_zero (timer_hit_w),
    .pick       (rr_pick_w)
  );

  irq_inj_seq #(.NCPU(NCPU), .VEC_W(VEC_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_w),
    .load_mask  (load_mask_w),
    .load_vec   (req_vector),
    .load_lvl   (req_level),
    .load_ovr   (timer_hit_w),
    .inj_valid  (inj_valid),
    .inj_cpu    (inj_cpu),
    .inj_vector (inj_vector),
    .inj_level  (inj_level),
    .idle       (seq_idle_w),
    .ovr_active (ovr_active_w)
  );

endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NCPU  = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             inj_valid,
  input logic [NCPU-1:0]  inj_cpu,
  input logic [VEC_W-1:0] inj_vector,
  input logic             load_w,
  input logic             ovr_active_w
);

  // R5
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> $countones(inj_cpu) == 1);

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> !req_ready);

  // R9
  load_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> inj_valid);

  // R7
  timer_cpu0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && ovr_active_w) |-> inj_cpu == NCPU'(1));

  // R5
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && $past(inj_valid) && !ovr_active_w) |-> inj_cpu > $past(inj_cpu));

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && $past(inj_valid)) |-> $stable(inj_vector));

  // R10
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_valid |-> inj_cpu == '0);

endmodule

bind irq_dispatch irq_dispatch_chk #(.NCPU(NCPU), .VEC_W(VEC_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .inj_valid    (inj_valid),
  .inj_cpu      (inj_cpu),
  .inj_vector   (inj_vector),
  .load_w       (load_w),
  .ovr_active_w (ovr_active_w)
);

// File: tb/irq_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_dest = '0;
  logic        req_logical = 1'b0;
  logic [2:0]  req_dmode = '0;
  logic [7:0]  req_vector = '0;
  logic        req_level = 1'b0;
  logic [4:0]  req_pin = '0;
  logic        timer_en = 1'b0;
  logic [63:0] cpu_phys_id;
  logic [7:0]  cpu_logic_hit = '0;
  logic        inj_valid;
  logic [7:0]  inj_cpu;
  logic [7:0]  inj_vector;
  logic        inj_level;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    mon_on  = 1'b0;
  bit    done    = 1'b0;
  int    rr_last = 7;
  logic [7:0] ids [8];

  int    exp_cpu [$];
  int    exp_vec [$];
  bit    exp_lvl [$];
  string exp_tag [$];

  always #2.5 clk = ~clk;

  irq_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_dmode(req_dmode),
    .req_vector(req_vector), .req_level(req_level), .req_pin(req_pin),
    .timer_en(timer_en), .cpu_phys_id(cpu_phys_id), .cpu_logic_hit(cpu_logic_hit),
    .inj_valid(inj_valid), .inj_cpu(inj_cpu), .inj_vector(inj_vector),
    .inj_level(inj_level)
  );

  initial begin
    for (int i = 0; i < 8; i++) ids[i] = 8'h10 + 8'(i);
    ids[5] = 8'h12;
  end
  always_comb for (int i = 0; i < 8; i++) cpu_phys_id[i*8 +: 8] = ids[i];

  // Monitor: pops the scoreboard on every injection.
  always @(negedge clk) begin
    if (mon_on && inj_valid) begin
      n_tests++;
      if (req_ready) begin
        n_fail++;
        $display("FAIL R9: ready=%b during injection, expected 0", req_ready);
      end
      if (exp_cpu.size() == 0) begin
        n_fail++;
        $display("FAIL R8: unexpected injection cpu=%b vec=%h, expected none", inj_cpu, inj_vector);
      end else begin
        automatic int    c = exp_cpu.pop_front();
        automatic int    v = exp_vec.pop_front();
        automatic bit    l = exp_lvl.pop_front();
        automatic string t = exp_tag.pop_front();
        if (inj_cpu !== (8'd1 << c) || inj_vector !== 8'(v) || inj_level !== l) begin
          n_fail++;
          $display("FAIL %s: cpu=%b vec=%h lvl=%b, expected cpu=%b vec=%h lvl=%b",
                   t, inj_cpu, inj_vector, inj_level, 8'd1 << c, 8'(v), l);
        end
      end
    end
  end

  task automatic push(input int c, input int v, input bit l, input string t);
    exp_cpu.push_back(c); exp_vec.push_back(v); exp_lvl.push_back(l); exp_tag.push_back(t);
  endtask

  task automatic send(input logic [7:0] dest, input bit lg, input logic [2:0] dm,
                      input logic [7:0] vec, input bit lvl, input logic [4:0] pin,
                      input bit ten, input logic [7:0] hits, input string tag);
    logic [7:0] set = '0;
    bit         ovr = ten && (pin == 5'd2);
    int         n0  = exp_cpu.size();
    int         nexp;
    if (!lg) begin
      if (dest == 8'hFF) set = 8'hFF;
      else for (int i = 0; i < 8; i++) if (ids[i] == dest) begin set[i] = 1'b1; break; end
    end else if (dest != 8'h00) set = hits;
    if (set != 0) begin
      if (dm == 3'd0 || dm == 3'd7) begin
        for (int i = 0; i < 8; i++) if (set[i]) push(ovr ? 0 : i, vec, lvl, tag);
      end else if (dm == 3'd1) begin
        if (ovr) begin push(0, vec, lvl, tag); rr_last = 0; end
        else for (int k = 1; k <= 8; k++) begin
          automatic int j = (rr_last + k) % 8;
          if (set[j]) begin push(j, vec, lvl, tag); rr_last = j; break; end
        end
      end
    end
    nexp = exp_cpu.size() - n0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_dest = dest; req_logical = lg; req_dmode = dm; req_vector = vec;
    req_level = lvl; req_pin = pin; timer_en = ten; cpu_logic_hit = hits;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    n_tests++;
    if (nexp == 0) begin
      // R4 / R8: dropped request leaves no injection and ready high
      if (inj_valid || !req_ready) begin
        n_fail++;
        $display("FAIL %s: inj_valid=%b ready=%b after drop, expected 0 1", tag, inj_valid, req_ready);
      end
    end else if (!inj_valid) begin
      n_fail++;
      $display("FAIL R9: inj_valid=%b the cycle after accept, expected 1", inj_valid);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    // R10 reset state
    if (inj_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: valid=%b ready=%b, expected 0 1", inj_valid, req_ready);
    end
    mon_on = 1'b1;

    send(8'hFF, 0, 3'd0, 8'h31, 0, 5'd4, 0, 8'h00, "R1");
    send(8'h12, 0, 3'd0, 8'h32, 1, 5'd4, 0, 8'h00, "R2");
    send(8'h17, 0, 3'd7, 8'h33, 0, 5'd4, 0, 8'h00, "R2");
    send(8'h15, 0, 3'd0, 8'h34, 0, 5'd4, 0, 8'hFF, "R4");
    send(8'h00, 1, 3'd0, 8'h35, 0, 5'd4, 0, 8'hFF, "R3");
    send(8'h0C, 1, 3'd7, 8'h36, 1, 5'd4, 0, 8'b1010_0100, "R3");
    send(8'h0C, 1, 3'd0, 8'h37, 0, 5'd4, 0, 8'h00, "R4");
    for (int r = 0; r < 4; r++) send(8'h03, 1, 3'd1, 8'h40, 1, 5'd4, 0, 8'b0110_0010, "R6");
    for (int m = 2; m <= 6; m++) send(8'hFF, 0, 3'(m), 8'h50, 0, 5'd4, 0, 8'h00, "R8");
    send(8'h03, 1, 3'd1, 8'h41, 0, 5'd4, 0, 8'b0110_0010, "R6");
    send(8'hFF, 0, 3'd0, 8'h60, 1, 5'd2, 1, 8'h00, "R7");
    send(8'h03, 1, 3'd1, 8'h61, 0, 5'd2, 1, 8'b0110_0000, "R7");
    send(8'h03, 1, 3'd1, 8'h62, 0, 5'd4, 0, 8'b0110_0010, "R6");
    send(8'h0C, 1, 3'd0, 8'h63, 0, 5'd2, 0, 8'b1000_0011, "R7");
    send(8'h0C, 1, 3'd0, 8'h64, 1, 5'd3, 1, 8'b1000_0011, "R5");
    send(8'hFF, 0, 3'd1, 8'h65, 0, 5'd4, 0, 8'h00, "R6");

    while (!req_ready || exp_cpu.size() != 0) begin
      if (exp_cpu.size() == 0 && !req_ready) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    n_tests++;
    if (exp_cpu.size() != 0 || !req_ready) begin
      n_fail++;
      $display("FAIL R5: %0d injections missing ready=%b, expected 0 1", exp_cpu.size(), req_ready);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule